// File: doc/BRIEF.md
# DMA Channel Register Space Decoder

This block sits on the physical-address path into the DMA register space of a larger chip. Each cycle it may see one access: an address, a read strobe, a write strobe and write data. It works out whether the address lands on one of the DMA channel register pages, on the page of the global DMA control block, or on nothing it knows. Channels that never move data are served locally. Each such channel holds four plain registers, and software can write and read them back. These channels run no transfer logic of any kind.

A channel that has a full transfer engine elsewhere in the chip is excluded through a parameter mask. Its accesses are flagged on a pass-through select together with the channel index, so the owning block can answer. Accesses to the global control page are flagged the same way. One cycle after every access the block reports an event with a region code. An address that matches no known page is reported as unmapped instead. Local reads, and reads of unmapped space, return a response one cycle after the strobe.

Top module: `dma_regspace_decoder`

## Requirements
- R1: After reset every local channel register reads as zero, and rsp_valid and evt_valid are low.
- R2: Channel pages are decoded from the physical address. Address bits [28:12] select one of these pages: 0x10008000 (index 0), 0x10009000 (1), 0x1000A000 (2), 0x1000B000 (3), 0x1000C000 (4), 0x1000D000 (5), or the shared page 0x1000F000. A channel access reports evt_region = 16 + channel index.
- R3: Within the shared page 0x1000F000, address bits [11:10] select the channel: 00 gives index 8, 01 gives index 9 and 10 gives index 10. The value 11 is unmapped.
- R4: An access whose address bits [28:12] equal those of 0x1000E000 raises gctrl_sel in the same cycle. One cycle later it reports evt_region = 13 with evt_unmapped low, and it produces no local rsp_valid.
- R5: Each local channel has four registers, at offsets 0x00 (control), 0x10 (memory address), 0x20 (quadword count) and 0x30 (tag address). A write updates the addressed register. A read returns its value on rsp_rdata, with rsp_valid high for exactly the one cycle after the read strobe.
- R6: The quadword count register keeps only its low QWC_W bits (default 16). Its upper read bits are zero.
- R7: Any other offset inside a local channel window reads as zero, with rsp_valid, and a write to it changes no register. For the 4 KiB pages the window is [11:0]. For the shared page it is [9:0].
- R8: An access that matches nothing gives evt_unmapped = 1 and evt_region = 0 one cycle later. A read of such an address gets rsp_valid with rsp_rdata = 0.
- R9: A channel set in EXT_MASK (by default only index 2) raises ext_sel in the same cycle, with ext_chan = channel index. It gives no local rsp_valid, and its event still carries 16 + index.
- R10: A write to one channel or register leaves every other channel register unchanged.
- R11: evt_valid is high in exactly the cycle after a cycle with a read or write strobe, and low otherwise.
- R12: When read and write strobes arrive together on a local register, the response carries the value held before the write, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | ADDR_W | Physical access address |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after a local or unmapped read |
| rsp_rdata | output | DATA_W | Read response data |
| evt_valid | output | 1 | Access event, one cycle after any strobe |
| evt_region | output | REGION_W | Region code of the reported access |
| evt_unmapped | output | 1 | Reported access matched no region |
| ext_sel | output | 1 | Same-cycle select for a channel served outside |
| ext_chan | output | 4 | Channel index for ext_sel |
| gctrl_sel | output | 1 | Same-cycle select for the global control page |

## Verification
A wrong page or slot decode shows up one cycle after the strobe. It appears as a wrong region code, a spurious unmapped flag, or a wrong same-cycle select. A latch that captures the wrong register, or captures when it should not, stays hidden until that register is read back. It is then seen on rsp_rdata one cycle after the read. For this reason the bench writes distinct values into every channel and register, and then reads them all. A missing or doubled response pulse shows on rsp_valid on the very next clock, which the bench compares on every access and idle cycle.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

   localparam int CH_IDX_W = 4;

   typedef enum logic [1:0] {
      RSEL_CTRL  = 2'd0,
      RSEL_MADDR = 2'd1,
      RSEL_QCNT  = 2'd2,
      RSEL_TAG   = 2'd3
   } rsel_e;

   typedef struct packed {
      logic                hit_chan;
      logic                hit_gctrl;
      logic [CH_IDX_W-1:0] chan;
      logic                reg_ok;
      rsel_e               rsel;
   } dec_t;

   // page number (address bits [31:12]) of each channel; zero means absent
   function automatic logic [19:0] chan_page(input int idx);
      case (idx)
         0:       return 20'h10008;
         1:       return 20'h10009;
         2:       return 20'h1000A;
         3:       return 20'h1000B;
         4:       return 20'h1000C;
         5:       return 20'h1000D;
         8, 9,
         10:      return 20'h1000F;
         default: return 20'h00000;
      endcase
   endfunction

   // 1 KiB slot (address bits [11:10]) for channels sharing a page
   function automatic logic [1:0] chan_slot(input int idx);
      case (idx)
         9:       return 2'd1;
         10:      return 2'd2;
         default: return 2'd0;
      endcase
   endfunction

   function automatic bit chan_present(input int idx);
      return chan_page(idx) != 20'h0;
   endfunction

   function automatic bit chan_subpage(input int idx);
      return idx >= 8;
   endfunction

endpackage

// File: rtl/dmareg_addr_decode.sv
module dmareg_addr_decode
   import dmareg_pkg::*;
#(
   parameter int          ADDR_W     = 29,
   parameter int          NUM_CH     = 11,
   parameter logic [31:0] GCTRL_BASE = 32'h1000_E000
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);

   localparam int PG_LO = 12;

   logic [19:0] pg;
   assign pg = 20'(addr[ADDR_W-1:PG_LO]);

   always_comb begin
      dec           = '0;
      dec.hit_gctrl = (pg == GCTRL_BASE[31:12]);
      dec.rsel      = rsel_e'(addr[5:4]);
      for (int c = 0; c < NUM_CH; c++) begin
         if (chan_present(c) && (pg == chan_page(c)) &&
             (!chan_subpage(c) || (addr[11:10] == chan_slot(c)))) begin
            dec.hit_chan = 1'b1;
            dec.chan     = CH_IDX_W'(c);
            if (chan_subpage(c))
               dec.reg_ok = (addr[3:0] == 4'h0) && (addr[9:6] == 4'h0);
            else
               dec.reg_ok = (addr[3:0] == 4'h0) && (addr[11:6] == 6'h0);
         end
      end
   end

endmodule

// File: rtl/dmareg_idle_chan.sv
module dmareg_idle_chan
   import dmareg_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int QWC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  rsel_e             rsel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_word
);

   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] maddr_q;
   logic [QWC_W-1:0]  qcnt_q;
   logic [DATA_W-1:0] tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         maddr_q <= '0;
         qcnt_q  <= '0;
         tag_q   <= '0;
      end else if (wr_en) begin
         case (rsel)
            RSEL_CTRL:  ctrl_q  <= wr_data;
            RSEL_MADDR: maddr_q <= wr_data;
            RSEL_QCNT:  qcnt_q  <= wr_data[QWC_W-1:0];
            RSEL_TAG:   tag_q   <= wr_data;
            default:    ;
         endcase
      end
   end

   always_comb begin
      case (rsel)
         RSEL_CTRL:  rd_word = ctrl_q;
         RSEL_MADDR: rd_word = maddr_q;
         RSEL_QCNT:  rd_word = DATA_W'(qcnt_q);
         default:    rd_word = tag_q;
      endcase
   end

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable({ctrl_q, maddr_q, qcnt_q, tag_q})); // R10

   AST_TAG_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rsel == RSEL_TAG) |=> (tag_q == $past(wr_data))); // R5

endmodule

// File: rtl/dmareg_resp.sv
module dmareg_resp
   import dmareg_pkg::*;
#(
   parameter int DATA_W           = 32,
   parameter int REGION_W         = 8,
   parameter int REGION_CHAN_BASE = 16,
   parameter int REGION_GCTRL     = 13
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_en,
   input  logic                wr_en,
   input  logic                hit_chan,
   input  logic                hit_local,
   input  logic                hit_gctrl,
   input  logic                reg_ok,
   input  logic [CH_IDX_W-1:0] chan,
   input  logic [DATA_W-1:0]   local_word,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic                evt_valid,
   output logic [REGION_W-1:0] evt_region,
   output logic                evt_unmapped
);

   logic acc;
   logic miss;
   logic [REGION_W-1:0] region_d;

   assign acc  = rd_en | wr_en;
   assign miss = !hit_chan && !hit_gctrl;

   always_comb begin
      if (hit_gctrl)
         region_d = REGION_W'(REGION_GCTRL);
      else if (hit_chan)
         region_d = REGION_W'(REGION_CHAN_BASE) + REGION_W'(chan);
      else
         region_d = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_rdata    <= '0;
         evt_valid    <= 1'b0;
         evt_region   <= '0;
         evt_unmapped <= 1'b0;
      end else begin
         evt_valid    <= acc;
         evt_region   <= acc ? region_d : '0;
         evt_unmapped <= acc && miss;
         rsp_valid    <= rd_en && (hit_local || miss);
         rsp_rdata    <= (rd_en && hit_local && reg_ok) ? local_word : '0;
      end
   end

   AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(rd_en)); // R5

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      evt_unmapped |-> (rsp_rdata == '0 && evt_region == '0)); // R8

   AST_EVT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en || wr_en) |=> !evt_valid); // R11

endmodule

// File: rtl/dma_regspace_decoder.sv
module dma_regspace_decoder
   import dmareg_pkg::*;
#(
   parameter int                ADDR_W           = 29,
   parameter int                DATA_W           = 32,
   parameter int                QWC_W            = 16,
   parameter int                NUM_CH           = 11,
   parameter logic [NUM_CH-1:0] EXT_MASK         = 11'b000_0000_0100,
   parameter int                REGION_W         = 8,
   parameter int                REGION_CHAN_BASE = 16,
   parameter int                REGION_GCTRL     = 13
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   acc_addr,
   input  logic                acc_rd,
   input  logic                acc_wr,
   input  logic [DATA_W-1:0]   acc_wdata,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic                evt_valid,
   output logic [REGION_W-1:0] evt_region,
   output logic                evt_unmapped,
   output logic                ext_sel,
   output logic [CH_IDX_W-1:0] ext_chan,
   output logic                gctrl_sel
);

   localparam int CHAN_CODE_TOP = REGION_CHAN_BASE + NUM_CH;

   if (ADDR_W < 29 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 29..32");
   end
   if (NUM_CH < 1 || NUM_CH > (1 << CH_IDX_W)) begin : g_bad_nch
      $error("NUM_CH out of range");
   end
   if (QWC_W < 1 || QWC_W > DATA_W) begin : g_bad_qwc
      $error("QWC_W must lie in 1..DATA_W");
   end
   if (CHAN_CODE_TOP > (1 << REGION_W) || REGION_GCTRL == 0 ||
       (REGION_GCTRL >= REGION_CHAN_BASE && REGION_GCTRL < CHAN_CODE_TOP)) begin : g_bad_code
      $error("region codes collide or overflow REGION_W");
   end

   dec_t dec;

   dmareg_addr_decode #(
      .ADDR_W (ADDR_W),
      .NUM_CH (NUM_CH)
   ) u_dec (
      .addr (acc_addr),
      .dec  (dec)
   );

   logic [DATA_W-1:0] chan_word [NUM_CH];
   logic              chan_is_ext;
   logic [DATA_W-1:0] local_word;
   logic              hit_local;
   logic              acc;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      if (chan_present(c) && !EXT_MASK[c]) begin : g_idle
         logic we;
         assign we = acc_wr && hit_local && dec.reg_ok && (dec.chan == CH_IDX_W'(c));
         dmareg_idle_chan #(
            .DATA_W (DATA_W),
            .QWC_W  (QWC_W)
         ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (we),
            .rsel    (dec.rsel),
            .wr_data (acc_wdata),
            .rd_word (chan_word[c])
         );
      end else begin : g_none
         assign chan_word[c] = '0;
      end
   end

   always_comb begin
      chan_is_ext = 1'b0;
      local_word  = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (dec.chan == CH_IDX_W'(c)) begin
            chan_is_ext = EXT_MASK[c];
            local_word  = chan_word[c];
         end
      end
   end

   assign acc       = acc_rd | acc_wr;
   assign hit_local = dec.hit_chan && !chan_is_ext;
   assign ext_sel   = acc && dec.hit_chan && chan_is_ext;
   assign ext_chan  = dec.chan;
   assign gctrl_sel = acc && dec.hit_gctrl;

   dmareg_resp #(
      .DATA_W           (DATA_W),
      .REGION_W         (REGION_W),
      .REGION_CHAN_BASE (REGION_CHAN_BASE),
      .REGION_GCTRL     (REGION_GCTRL)
   ) u_resp (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_en        (acc_rd),
      .wr_en        (acc_wr),
      .hit_chan     (dec.hit_chan),
      .hit_local    (hit_local),
      .hit_gctrl    (dec.hit_gctrl),
      .reg_ok       (dec.reg_ok),
      .chan         (dec.chan),
      .local_word   (local_word),
      .rsp_valid    (rsp_valid),
      .rsp_rdata    (rsp_rdata),
      .evt_valid    (evt_valid),
      .evt_region   (evt_region),
      .evt_unmapped (evt_unmapped)
   );

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({acc && hit_local, ext_sel, gctrl_sel})); // R9

   AST_EXT_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      ext_sel |=> !rsp_valid); // R9

   AST_GCTRL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      gctrl_sel |=> (evt_region == REGION_W'(REGION_GCTRL) && !evt_unmapped && !rsp_valid)); // R4

endmodule

// File: tb/sim_dma_regspace_decoder.sv
module sim_dma_regspace_decoder;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [28:0] acc_addr = '0;
   logic        acc_rd = 1'b0;
   logic        acc_wr = 1'b0;
   logic [31:0] acc_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        evt_valid;
   logic [7:0]  evt_region;
   logic        evt_unmapped;
   logic        ext_sel;
   logic [3:0]  ext_chan;
   logic        gctrl_sel;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_regspace_decoder u0 (
      .clk (clk), .rst_n (rst_n),
      .acc_addr (acc_addr), .acc_rd (acc_rd), .acc_wr (acc_wr), .acc_wdata (acc_wdata),
      .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
      .evt_valid (evt_valid), .evt_region (evt_region), .evt_unmapped (evt_unmapped),
      .ext_sel (ext_sel), .ext_chan (ext_chan), .gctrl_sel (gctrl_sel)
   );

   int n_chk = 0;
   int n_fail = 0;
   int unsigned model [int];
   int local_ch [8] = '{0, 1, 3, 4, 5, 8, 9, 10};

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] base_of(input int ch);
      if (ch < 8) return 32'h1000_8000 + 32'(ch) * 32'h1000;
      return 32'h1000_F000 + 32'(ch - 8) * 32'h400;
   endfunction

   // kind: 0 unmapped, 1 channel, 2 global control
   task automatic ref_decode(input logic [31:0] a, output int kind, output int ch, output int roff);
      int off;
      kind = 1; ch = -1; roff = -1;
      case (a[28:12])
         17'h10008: ch = 0;
         17'h10009: ch = 1;
         17'h1000A: ch = 2;
         17'h1000B: ch = 3;
         17'h1000C: ch = 4;
         17'h1000D: ch = 5;
         17'h1000E: kind = 2;
         17'h1000F: if (a[11:10] != 2'b11) ch = 8 + int'(a[11:10]);
         default:   ;
      endcase
      if (kind == 1 && ch < 0) kind = 0;
      if (kind == 1) begin
         off = (ch < 8) ? int'(a[11:0]) : int'(a[9:0]);
         if (off < 'h40 && (off % 16) == 0) roff = off / 16;
      end
   endtask

   task automatic access(input logic [31:0] a, input bit rd, input bit wr,
                         input logic [31:0] d, input string req);
      int kind, ch, roff, key;
      bit ext;
      logic [31:0] exp_data;
      @(negedge clk);
      acc_addr = a[28:0]; acc_rd = rd; acc_wr = wr; acc_wdata = d;
      #1;
      ref_decode(a, kind, ch, roff);
      ext = (kind == 1 && ch == 2);
      chk(req, "ext_sel", ext_sel, ext);
      chk(req, "gctrl_sel", gctrl_sel, kind == 2);
      if (ext) chk(req, "ext_chan", ext_chan, 2);
      key = ch * 4 + roff;
      exp_data = 0;
      if (rd && kind == 1 && !ext && roff >= 0 && model.exists(key)) exp_data = model[key];
      if (wr && kind == 1 && !ext && roff >= 0) model[key] = (roff == 2) ? (d & 32'hFFFF) : d;
      @(posedge clk);
      #1;
      acc_rd = 1'b0; acc_wr = 1'b0;
      chk("R11", "evt_valid", evt_valid, 1);
      chk(req, "evt_region", evt_region, kind == 2 ? 13 : (kind == 1 ? 16 + ch : 0));
      chk(req, "evt_unmapped", evt_unmapped, kind == 0);
      chk(req, "rsp_valid", rsp_valid, rd && ((kind == 1 && !ext) || kind == 0));
      chk(req, "rsp_rdata", rsp_rdata, exp_data);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         chk("R11", "idle evt_valid", evt_valid, 0);
         chk("R11", "idle rsp_valid", rsp_valid, 0);
      end
   endtask

   task automatic read_all(input string req);
      for (int i = 0; i < 8; i++)
         for (int r = 0; r < 4; r++)
            access(base_of(local_ch[i]) + 32'(r * 16), 1'b1, 1'b0, 32'h0, req);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "reset rsp_valid", rsp_valid, 0);
      chk("R1", "reset evt_valid", evt_valid, 0);
      @(negedge clk); rst_n = 1'b1;
      idle(2);
      read_all("R1");

      // distinct values in every register of every local channel
      for (int i = 0; i < 8; i++)
         for (int r = 0; r < 4; r++)
            access(base_of(local_ch[i]) + 32'(r * 16), 1'b0, 1'b1,
                   32'hA500_0000 + 32'(local_ch[i] << 8) + 32'(r), "R5");
      read_all("R10");

      // quadword count keeps low 16 bits
      access(32'h1000_C020, 1'b0, 1'b1, 32'hFFFF_ABCD, "R6");
      access(32'h1000_C020, 1'b1, 1'b0, 32'h0, "R6");

      // unused offsets: zero reads, writes ignored
      access(32'h1000_8040, 1'b0, 1'b1, 32'hDEAD_BEEF, "R7");
      access(32'h1000_8004, 1'b0, 1'b1, 32'hDEAD_BEEF, "R7");
      access(32'h1000_8FF0, 1'b0, 1'b1, 32'hDEAD_BEEF, "R7");
      access(32'h1000_8040, 1'b1, 1'b0, 32'h0, "R7");
      access(32'h1000_F7F0, 1'b1, 1'b0, 32'h0, "R7");
      read_all("R7");

      // shared page slots
      access(32'h1000_F410, 1'b0, 1'b1, 32'h0909_0909, "R3");
      access(32'h1000_F410, 1'b1, 1'b0, 32'h0, "R3");
      access(32'h1000_F830, 1'b1, 1'b0, 32'h0, "R3");
      access(32'h1000_FC00, 1'b1, 1'b0, 32'h0, "R3");
      access(32'h1000_FC00, 1'b0, 1'b1, 32'h1234_5678, "R3");
      access(32'h1000_F000, 1'b1, 1'b0, 32'h0, "R2");

      // global control page
      access(32'h1000_E010, 1'b1, 1'b0, 32'h0, "R4");
      access(32'h1000_EFF0, 1'b0, 1'b1, 32'h5555_AAAA, "R4");

      // unmapped space
      access(32'h1000_7000, 1'b1, 1'b0, 32'h0, "R8");
      access(32'h1001_0000, 1'b0, 1'b1, 32'hFFFF_FFFF, "R8");
      access(32'h0000_8000, 1'b1, 1'b0, 32'h0, "R8");

      // externally served channel
      access(32'h1000_A000, 1'b0, 1'b1, 32'h2222_2222, "R9");
      access(32'h1000_A010, 1'b1, 1'b0, 32'h0, "R9");
      idle(3);

      // read and write together
      access(32'h1000_D000, 1'b1, 1'b1, 32'h7777_0001, "R12");
      access(32'h1000_D000, 1'b1, 1'b0, 32'h0, "R12");
      access(32'h1000_9030, 1'b1, 1'b1, 32'h7777_0002, "R12");

      read_all("R10");
      idle(2);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule